// File: doc/BRIEF.md
# Secure-Gated Cache Auxiliary Control Register

This block holds one 32-bit word of configuration for a cache memory subsystem. Software reaches it through a single-cycle request port. Each request carries a write flag, the requester's security state and its privilege level. Every request gets a registered response one cycle later. The response carries read data, an access-fault flag and a write-reject flag.

The block decides what each request may do. Non-secure requesters may only read the word. Secure requesters at privilege level 1 or above may also write it. Requests at privilege level 0 are refused. A permitted write is kept only when the subsystem is idle, which means no coherence snoop and no accelerator-port request is outstanding. A permitted write made while the subsystem is busy is dropped and flagged.

Nineteen implemented bits are stored. The remaining positions are reserved: they always read as zero and no write can set them. Each implemented bit drives its own named output, which downstream clock-gating, coherence and cache-pipeline logic treat as a static setting.

Top module: `cache_aux_ctl_reg`

## Requirements
- R1: After reset, every control output is 0, the stored word reads back as 0, and rsp_valid, rsp_fault and wr_reject are 0.
- R2: A write with req_secure=1 and req_priv>=1 while snoop_pending=0 and accel_pending=0 stores req_wdata. The new value appears on the control outputs one clock after the request.
- R3: Bit positions 31..29, 25..17 and 5 always read as 0 and ignore writes. The implemented mask is 32'h1C01_FFDF.
- R4: Every request asserts rsp_valid exactly one clock later. A permitted read returns the stored word on rsp_rdata in that cycle. Write responses return 0.
- R5: With req_secure=0 and req_priv>=1, reads return the stored word. Writes leave it unchanged and raise neither rsp_fault nor wr_reject.
- R6: A request with req_priv=0 raises rsp_fault in its response cycle, returns rsp_rdata=0 and leaves the stored word unchanged.
- R7: A secure write at req_priv>=1 made while snoop_pending or accel_pending is 1 is dropped. The stored word is unchanged, and wr_reject is 1 for the single response cycle of that request.
- R8: Each control output equals the stored bit at the position given for it in the Ports table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | 1 = Secure requester |
| req_priv | input | 2 | Requester privilege level, 0..3 |
| req_wdata | input | 32 | Write data |
| snoop_pending | input | 1 | Coherence snoop outstanding |
| accel_pending | input | 1 | Accelerator-port request outstanding |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_rdata | output | 32 | Read data |
| rsp_fault | output | 1 | Privilege fault |
| wr_reject | output | 1 | Write dropped because subsystem busy |
| tagbank_clk_hold | output | 1 | Bit 28: keep tag bank clocks running |
| logic_clk_hold | output | 1 | Bit 27: keep cache logic clock running |
| region_gate_en | output | 1 | Bit 26: allow regional clock gates |
| replay_single_issue_en | output | 1 | Bit 16: force single issue after repeated replays |
| wfi_retention_en | output | 1 | Bit 15: retention while cores wait for interrupt |
| clean_evict_data_en | output | 1 | Bit 14: send data with clean-unique evictions |
| shared_clean_xfer_dis | output | 1 | Bit 13: block shared-clean data transfers |
| same_id_wb_serialize | output | 1 | Bit 12: one writeback in flight per write ID |
| barrier_no_dvm_dis | output | 1 | Bit 11: barrier always includes DVM sync |
| ns_debug_read_dis | output | 1 | Bit 10: block non-secure debug array reads |
| prefetch_repl_en | output | 1 | Bit 9: replacement policy uses prefetch flag |
| broadcast_dis | output | 1 | Bit 8: block DVM and maintenance broadcast |
| hazard_timeout_en | output | 1 | Bit 7: hazard detect timeout |
| shareable_dis | output | 1 | Bit 6: block shareable transactions |
| write_unique_dis | output | 1 | Bit 4: block write-unique transactions |
| push_external_dis | output | 1 | Bit 3: block clean/evict push downstream |
| one_per_bank | output | 1 | Bit 2: one request per tag bank |
| replay_timeout_en | output | 1 | Bit 1: arbitration replay timeout |
| prefetch_fwd_dis | output | 1 | Bit 0: block prefetch forwarding |

## Verification
A corrupted stored word shows on the control outputs immediately, and on rsp_rdata in the response to the next permitted read. A bad access decision shows one clock after the offending request, either as a wrong rsp_fault or wr_reject value or as a control output that changed when it should have held. The sweep crosses every security state, privilege level, request type and busy combination with varied data. Single-bit writes confirm which output belongs to which bit position.

// File: rtl/cactl_pkg.sv
`timescale 1ns/1ps
package cactl_pkg;
  localparam int CTL_W = 32;
  // implemented positions: 28..26, 16..6, 4..0
  localparam logic [CTL_W-1:0] CTL_IMPL_MASK = 32'h1C01_FFDF;

  typedef enum logic [1:0] {
    ACC_DENY = 2'd0,
    ACC_RO   = 2'd1,
    ACC_RW   = 2'd2
  } acc_e;
endpackage

// File: rtl/cactl_access_decode.sv
`timescale 1ns/1ps
module cactl_access_decode
  import cactl_pkg::*;
#(
  parameter int PRIV_W   = 2,
  parameter int MIN_PRIV = 1
) (
  input  logic              req_secure,
  input  logic [PRIV_W-1:0] req_priv,
  output acc_e              mode
);
  localparam logic [PRIV_W-1:0] MinLvl = PRIV_W'(MIN_PRIV);

  always_comb begin
    if (req_priv < MinLvl)  mode = ACC_DENY;
    else if (req_secure)    mode = ACC_RW;
    else                    mode = ACC_RO;
  end
endmodule

// File: rtl/cactl_store.sv
`timescale 1ns/1ps
module cactl_store #(
  parameter int               W    = 32,
  parameter logic [W-1:0]     MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_next;

  always_comb begin
    q_next = q_r;
    if (wr_en) q_next = wdata & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_next;
  end

  // reserved positions tied off at the output
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_impl
      assign q[i] = q_r[i];
    end else begin : g_rsvd
      assign q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/cactl_resp.sv
`timescale 1ns/1ps
module cactl_resp #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic         rd_en,
  input  logic [W-1:0] rd_word,
  input  logic         deny,
  input  logic         busy_drop,
  output logic         rsp_valid,
  output logic [W-1:0] rsp_rdata,
  output logic         rsp_fault,
  output logic         wr_reject
);
  logic         valid_n, fault_n, rej_n;
  logic [W-1:0] data_n;

  always_comb begin
    valid_n = req_valid;
    data_n  = rd_en ? rd_word : '0;
    fault_n = deny;
    rej_n   = busy_drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_fault <= 1'b0;
      wr_reject <= 1'b0;
    end else begin
      rsp_valid <= valid_n;
      rsp_rdata <= data_n;
      rsp_fault <= fault_n;
      wr_reject <= rej_n;
    end
  end
endmodule

// File: rtl/cache_aux_ctl_reg.sv
`timescale 1ns/1ps
module cache_aux_ctl_reg
  import cactl_pkg::*;
#(
  parameter int PRIV_W   = 2,
  parameter int MIN_PRIV = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_secure,
  input  logic [PRIV_W-1:0] req_priv,
  input  logic [CTL_W-1:0]  req_wdata,
  input  logic              snoop_pending,
  input  logic              accel_pending,
  output logic              rsp_valid,
  output logic [CTL_W-1:0]  rsp_rdata,
  output logic              rsp_fault,
  output logic              wr_reject,
  output logic              tagbank_clk_hold,
  output logic              logic_clk_hold,
  output logic              region_gate_en,
  output logic              replay_single_issue_en,
  output logic              wfi_retention_en,
  output logic              clean_evict_data_en,
  output logic              shared_clean_xfer_dis,
  output logic              same_id_wb_serialize,
  output logic              barrier_no_dvm_dis,
  output logic              ns_debug_read_dis,
  output logic              prefetch_repl_en,
  output logic              broadcast_dis,
  output logic              hazard_timeout_en,
  output logic              shareable_dis,
  output logic              write_unique_dis,
  output logic              push_external_dis,
  output logic              one_per_bank,
  output logic              replay_timeout_en,
  output logic              prefetch_fwd_dis
);
  acc_e             mode;
  logic             sys_idle;
  logic             wr_req, wr_commit, wr_busy, rd_ok, deny;
  logic [CTL_W-1:0] ctl_q;

  cactl_access_decode #(.PRIV_W(PRIV_W), .MIN_PRIV(MIN_PRIV)) u_dec (
    .req_secure (req_secure),
    .req_priv   (req_priv),
    .mode       (mode)
  );

  assign sys_idle  = !snoop_pending && !accel_pending;
  assign wr_req    = req_valid && req_write && (mode == ACC_RW);
  assign wr_commit = wr_req && sys_idle;
  assign wr_busy   = wr_req && !sys_idle;
  assign rd_ok     = req_valid && !req_write && (mode != ACC_DENY);
  assign deny      = req_valid && (mode == ACC_DENY);

  cactl_store #(.W(CTL_W), .MASK(CTL_IMPL_MASK)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_commit),
    .wdata (req_wdata),
    .q     (ctl_q)
  );

  cactl_resp #(.W(CTL_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .rd_en     (rd_ok),
    .rd_word   (ctl_q),
    .deny      (deny),
    .busy_drop (wr_busy),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_fault (rsp_fault),
    .wr_reject (wr_reject)
  );

  // control fan-out; positions fixed by the field layout
  assign tagbank_clk_hold       = ctl_q[28];
  assign logic_clk_hold         = ctl_q[27];
  assign region_gate_en         = ctl_q[26];
  assign replay_single_issue_en = ctl_q[16];
  assign wfi_retention_en       = ctl_q[15];
  assign clean_evict_data_en    = ctl_q[14];
  assign shared_clean_xfer_dis  = ctl_q[13];
  assign same_id_wb_serialize   = ctl_q[12];
  assign barrier_no_dvm_dis     = ctl_q[11];
  assign ns_debug_read_dis      = ctl_q[10];
  assign prefetch_repl_en       = ctl_q[9];
  assign broadcast_dis          = ctl_q[8];
  assign hazard_timeout_en      = ctl_q[7];
  assign shareable_dis          = ctl_q[6];
  assign write_unique_dis       = ctl_q[4];
  assign push_external_dis      = ctl_q[3];
  assign one_per_bank           = ctl_q[2];
  assign replay_timeout_en      = ctl_q[1];
  assign prefetch_fwd_dis       = ctl_q[0];
endmodule

// File: rtl/cactl_checker.sv
`timescale 1ns/1ps
module cactl_checker
  import cactl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic             req_secure,
  input logic [1:0]       req_priv,
  input logic [CTL_W-1:0] req_wdata,
  input logic             snoop_pending,
  input logic             accel_pending,
  input logic             rsp_valid,
  input logic [CTL_W-1:0] rsp_rdata,
  input logic             rsp_fault,
  input logic             wr_reject,
  input logic [CTL_W-1:0] ctl
);
  // R2
  idle_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_secure && req_priv != 2'd0 &&
     !snoop_pending && !accel_pending)
    |=> ctl == ($past(req_wdata) & CTL_IMPL_MASK));

  // R3
  rsvd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_rdata & ~CTL_IMPL_MASK) == '0);

  // R4
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R5
  nonsecure_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_secure) |=> ($stable(ctl) && !wr_reject));

  // R6
  low_priv_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_priv == 2'd0) |=> (rsp_fault && rsp_rdata == '0 && $stable(ctl)));

  // R7
  busy_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |-> $stable(ctl));
endmodule

bind cache_aux_ctl_reg cactl_checker u_cactl_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_write     (req_write),
  .req_secure    (req_secure),
  .req_priv      (req_priv),
  .req_wdata     (req_wdata),
  .snoop_pending (snoop_pending),
  .accel_pending (accel_pending),
  .rsp_valid     (rsp_valid),
  .rsp_rdata     (rsp_rdata),
  .rsp_fault     (rsp_fault),
  .wr_reject     (wr_reject),
  .ctl           (ctl_q)
);

// File: tb/cache_aux_ctl_reg_bench.sv
`timescale 1ns/1ps
module cache_aux_ctl_reg_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write, req_secure;
  logic [1:0] req_priv;
  logic [31:0] req_wdata;
  logic snoop_pending, accel_pending;
  logic rsp_valid, rsp_fault, wr_reject;
  logic [31:0] rsp_rdata;
  logic o28, o27, o26, o16, o15, o14, o13, o12, o11, o10, o9, o8, o7, o6, o4, o3, o2, o1, o0;
  logic [31:0] obs;

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] exp_reg;
  // reserved: 31..29, 25..17, 5
  localparam logic [31:0] MASK = ~(32'hE000_0000 | 32'h03FE_0000 | 32'h0000_0020);

  always #2.5 clk = ~clk;

  cache_aux_ctl_reg u_cache_aux_ctl_reg (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_secure(req_secure), .req_priv(req_priv), .req_wdata(req_wdata),
    .snoop_pending(snoop_pending), .accel_pending(accel_pending),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault),
    .wr_reject(wr_reject),
    .tagbank_clk_hold(o28), .logic_clk_hold(o27), .region_gate_en(o26),
    .replay_single_issue_en(o16), .wfi_retention_en(o15), .clean_evict_data_en(o14),
    .shared_clean_xfer_dis(o13), .same_id_wb_serialize(o12), .barrier_no_dvm_dis(o11),
    .ns_debug_read_dis(o10), .prefetch_repl_en(o9), .broadcast_dis(o8),
    .hazard_timeout_en(o7), .shareable_dis(o6), .write_unique_dis(o4),
    .push_external_dis(o3), .one_per_bank(o2), .replay_timeout_en(o1),
    .prefetch_fwd_dis(o0)
  );

  always_comb begin
    obs = '0;
    obs[28] = o28; obs[27] = o27; obs[26] = o26;
    obs[16] = o16; obs[15] = o15; obs[14] = o14; obs[13] = o13; obs[12] = o12;
    obs[11] = o11; obs[10] = o10; obs[9]  = o9;  obs[8]  = o8;  obs[7]  = o7;
    obs[6]  = o6;  obs[4]  = o4;  obs[3]  = o3;  obs[2]  = o2;  obs[1]  = o1;
    obs[0]  = o0;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the response
  task automatic apply(input bit sec, input logic [1:0] prv, input bit wr,
                       input bit snp, input bit acc, input logic [31:0] d);
    logic [31:0] e_rd;
    bit e_flt, e_rej;
    string st;
    req_valid = 1'b1; req_write = wr; req_secure = sec; req_priv = prv;
    req_wdata = d; snoop_pending = snp; accel_pending = acc;
    e_flt = (prv == 2'd0);
    e_rd  = (!wr && !e_flt) ? exp_reg : 32'h0;
    e_rej = wr && sec && !e_flt && (snp || acc);
    if (wr && sec && !e_flt && !snp && !acc) exp_reg = d & MASK;
    st = e_flt ? "R6" : (e_rej ? "R7" : (wr ? (sec ? "R2" : "R5") : "R4"));
    @(negedge clk);
    chk(rsp_valid === 1'b1, "R4 rsp_valid", {31'b0, rsp_valid}, 32'h1);
    chk(rsp_rdata === e_rd, e_flt ? "R6 rdata" : "R4 rdata", rsp_rdata, e_rd);
    chk((rsp_rdata & ~MASK) === 32'h0, "R3 reserved read", rsp_rdata & ~MASK, 32'h0);
    chk(rsp_fault === e_flt, "R6 fault", {31'b0, rsp_fault}, {31'b0, e_flt});
    chk(wr_reject === e_rej, "R7 reject", {31'b0, wr_reject}, {31'b0, e_rej});
    chk(obs === exp_reg, {st, " control outputs"}, obs, exp_reg);
    req_valid = 1'b0; snoop_pending = 1'b0; accel_pending = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_secure = 1'b0;
    req_priv = 2'd0; req_wdata = '0; snoop_pending = 1'b0; accel_pending = 1'b0;
    exp_reg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(obs === 32'h0, "R1 outputs", obs, 32'h0);
    chk({rsp_valid, rsp_fault, wr_reject} === 3'b000, "R1 response flags",
        {29'b0, rsp_valid, rsp_fault, wr_reject}, 32'h0);
    apply(1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0);  // R1 read-back zero

    // full cross of security, privilege, direction and busy inputs
    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < 64; c++) begin
        logic [31:0] d;
        d = 32'hA5C3_96F1 ^ (32'(c + 64*k) * 32'h9E37_79B9);
        if (c == 5)  d = 32'hFFFF_FFFF;
        if (c == 37) d = 32'h0;
        apply(c[0], c[2:1], c[3], c[4], c[5], d);
        apply(c[5], 2'd2, 1'b0, c[0], c[1], 32'h0);  // follow-up read
      end
    end

    // R8 walking one across all positions, plus readback
    for (int i = 0; i < 32; i++) begin
      apply(1'b1, 2'd3, 1'b1, 1'b0, 1'b0, 32'h1 << i);
      chk(obs === ((32'h1 << i) & MASK), "R8 bit position", obs, (32'h1 << i) & MASK);
      apply(1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0);
    end

    // R7 busy write with each pending source after a known value
    apply(1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 32'h1C01_0F0F);
    apply(1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 32'h0000_F0F0);
    apply(1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 32'h0000_F0F0);
    apply(1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule